// File: doc/BRIEF.md
# Power Mode Sequencing Controller

This block walks a mixed-signal LED-driver chip through its power modes: held in reset, parked in a low-power standby, bringing up its reference, bias and oscillator, soft-starting the boost converter, and finally normal operation. Two register bits in a control byte steer it. One bit releases the chip from standby and the other asks for the boost converter. An external active-low reset and a power-on-reset flag force it back to reset from any mode. A thermal-shutdown flag holds it in the startup mode until the flag clears.

The block also keeps a small byte-wide register file with a one-cycle write port and a combinational read port. Every register clears to 00h on reset, except the boost output-voltage register, which returns to 3Fh. The two settling delays (startup and boost soft-start) are counted in clock cycles, and a parameter sets their length. It defaults to one hundredth of the clock rate, which is 10 ms.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: Whenever `ext_rst_n` is low or `por_flag` is high at a clock edge, `mode` is 0 (reset) after that edge and all four enables are 0, whatever the prior mode.
- R2: While reset is requested, every register reads 00h after the next edge, except address 1 (boost output voltage), which reads 3Fh.
- R3: One edge after the reset request drops, `mode` is 1 (standby) with all enables 0. Writes made in standby are stored and readable at once, and they change no enable.
- R4: With the wake bit (bit 0 of address 0) at 1 in standby, `mode` becomes 2 (startup) on the next edge and `bias_en` is 1.
- R5: Startup lasts exactly DELAY_CYCLES edges. It then moves to mode 3 if the boost bit (bit 1 of address 0) is 1, or to mode 4 (normal) with the boost off if that bit is 0.
- R6: A high `thsd_flag` in mode 2, 3 or 4 gives mode 2 on the next edge with boost off. The delay count restarts, and a full DELAY_CYCLES edges are counted from the first edge at which the flag is low.
- R7: In mode 3, `boost_en` and `boost_pfm` are both 1. After DELAY_CYCLES edges the mode becomes 4, with `boost_en` 1 and `boost_pfm` 0.
- R8: In normal mode with the boost off, writing the boost bit to 1 gives mode 3 one edge after the write edge.
- R9: In normal mode, writing the boost bit to 0 drops `boost_en` from the write edge on, and the mode stays 4.
- R10: If the wake bit is 0 at an edge, any mode other than reset goes to mode 1 on that edge.
- R11: Writes are ignored while reset is requested. A write replaces all 8 bits of the addressed register, and the registers may be written in any order.
- R12: `func_en` is 1 only in mode 4 and `bias_en` only in modes 2, 3 and 4. The mode codes are 0 reset, 1 standby, 2 startup, 3 boost soft-start and 4 normal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset, released synchronously |
| ext_rst_n | input | 1 | External active-low reset request, synchronous |
| por_flag | input | 1 | Power-on-reset flag, active high |
| thsd_flag | input | 1 | Thermal-shutdown flag, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W (3) | Register write address |
| wr_data | input | DATA_W (8) | Register write data |
| rd_addr | input | ADDR_W (3) | Register read address |
| rd_data | output | DATA_W (8) | Register read data, combinational |
| mode | output | 3 | Current mode code |
| bias_en | output | 1 | Reference, bias and oscillator enable |
| boost_en | output | 1 | Boost converter enable |
| boost_pfm | output | 1 | Boost soft-start (PFM) indication |
| func_en | output | 1 | Normal-mode function enable |

## Verification
A register write is visible on `rd_data` right after its write edge. A mode change caused by that write appears one edge later, because the state register reads the stored control bits. The exception is the boost turn-off, which appears on the write edge itself. Reset, thermal and wake-drop changes take effect on the first edge at which they are sampled. Each timed mode lasts exactly DELAY_CYCLES edges from its entry edge. The bench drives inputs at the falling edge, counts the rising edges each result needs, and samples at the following falling edge, one edge short of each delay and then on the edge itself.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  typedef enum logic [2:0] {
    MODE_RESET   = 3'd0,
    MODE_STANDBY = 3'd1,
    MODE_STARTUP = 3'd2,
    MODE_SOFTST  = 3'd3,
    MODE_NORMAL  = 3'd4
  } pwr_mode_e;

  localparam int unsigned CTRL_ADDR    = 0;
  localparam int unsigned VOUT_ADDR    = 1;
  localparam int unsigned WAKE_BIT     = 0;
  localparam int unsigned BOOST_BIT    = 1;
  localparam logic [7:0]  VOUT_DEFAULT = 8'h3F;

endpackage

// File: rtl/pwr_seq_regs.sv
module pwr_seq_regs
  import pwr_seq_pkg::*;
#(
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned DATA_W   = 8,
  localparam int unsigned ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] ctrl_q,
  output logic [DATA_W-1:0] vout_q
);

  logic [DATA_W-1:0] regs_q [NUM_REGS];

  for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
    localparam logic [DATA_W-1:0] RST_VAL =
      (gi == VOUT_ADDR) ? DATA_W'(VOUT_DEFAULT) : '0;
    logic hit;
    assign hit = we && (waddr == ADDR_W'(gi));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs_q[gi] <= RST_VAL;
      end else if (clr) begin
        regs_q[gi] <= RST_VAL;
      end else if (hit) begin
        regs_q[gi] <= wdata;
      end
    end
  end

  assign rdata  = regs_q[raddr];
  assign ctrl_q = regs_q[CTRL_ADDR];
  assign vout_q = regs_q[VOUT_ADDR];

endmodule

// File: rtl/pwr_seq_timer.sv
module pwr_seq_timer #(
  parameter int unsigned DELAY_CYCLES = 500000,
  localparam int unsigned CNT_W = (DELAY_CYCLES > 2) ? $clog2(DELAY_CYCLES) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic done
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign done   = run && (cnt_q == CNT_W'(DELAY_CYCLES - 1));
  assign cnt_en = clr || run;

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (run) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
  import pwr_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      rst_req,
  input  logic      thsd,
  input  logic      wake,
  input  logic      boost_req,
  input  logic      dly_done,
  output pwr_mode_e state_q,
  output logic      boost_on_q,
  output logic      tmr_clr,
  output logic      tmr_run
);

  pwr_mode_e state_d;
  logic      boost_on_d;

  always_comb begin
    state_d = state_q;
    if (rst_req) begin
      state_d = MODE_RESET;
    end else if (state_q == MODE_RESET) begin
      state_d = MODE_STANDBY;
    end else if (!wake) begin
      state_d = MODE_STANDBY;
    end else begin
      case (state_q)
        MODE_STANDBY: state_d = MODE_STARTUP;
        MODE_STARTUP: begin
          if (!thsd && dly_done) begin
            state_d = boost_req ? MODE_SOFTST : MODE_NORMAL;
          end
        end
        MODE_SOFTST: begin
          if (thsd) begin
            state_d = MODE_STARTUP;
          end else if (!boost_req || dly_done) begin
            state_d = MODE_NORMAL;
          end
        end
        MODE_NORMAL: begin
          if (thsd) begin
            state_d = MODE_STARTUP;
          end else if (boost_req && !boost_on_q) begin
            state_d = MODE_SOFTST;
          end
        end
        default: state_d = MODE_RESET;
      endcase
    end
  end

  always_comb begin
    boost_on_d = 1'b0;
    if (state_d == MODE_NORMAL) begin
      if (state_q == MODE_SOFTST) begin
        boost_on_d = boost_req;
      end else if (state_q == MODE_NORMAL) begin
        boost_on_d = boost_on_q && boost_req;
      end
    end
  end

  assign tmr_run = ((state_q == MODE_STARTUP) && !thsd) || (state_q == MODE_SOFTST);
  assign tmr_clr = (state_d != state_q) || ((state_q == MODE_STARTUP) && thsd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= MODE_RESET;
      boost_on_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      boost_on_q <= boost_on_d;
    end
  end

endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
#(
  parameter int unsigned CLK_HZ       = 50_000_000,
  parameter int unsigned DELAY_CYCLES = CLK_HZ / 100,
  parameter int unsigned NUM_REGS     = 8,
  parameter int unsigned DATA_W       = 8,
  localparam int unsigned ADDR_W      = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_rst_n,
  input  logic              por_flag,
  input  logic              thsd_flag,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [2:0]        mode,
  output logic              bias_en,
  output logic              boost_en,
  output logic              boost_pfm,
  output logic              func_en
);

  logic [1:0]        rst_sync_q;
  logic              rst_s_n;
  logic              rst_req;
  logic              reg_we;
  logic [DATA_W-1:0] ctrl_q;
  logic [DATA_W-1:0] vout_q;
  logic              wake_bit;
  logic              boost_bit;
  logic              dly_done;
  logic              tmr_clr;
  logic              tmr_run;
  logic              boost_on_q;
  pwr_mode_e         state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_s_n = rst_sync_q[1];

  assign rst_req   = !ext_rst_n || por_flag;
  assign reg_we    = wr_en && !rst_req && (state_q != MODE_RESET);
  assign wake_bit  = ctrl_q[WAKE_BIT];
  assign boost_bit = ctrl_q[BOOST_BIT];

  pwr_seq_regs #(
    .NUM_REGS (NUM_REGS),
    .DATA_W   (DATA_W)
  ) i_regs (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .clr    (rst_req),
    .we     (reg_we),
    .waddr  (wr_addr),
    .wdata  (wr_data),
    .raddr  (rd_addr),
    .rdata  (rd_data),
    .ctrl_q (ctrl_q),
    .vout_q (vout_q)
  );

  pwr_seq_timer #(
    .DELAY_CYCLES (DELAY_CYCLES)
  ) i_timer (
    .clk   (clk),
    .rst_n (rst_s_n),
    .clr   (tmr_clr),
    .run   (tmr_run),
    .done  (dly_done)
  );

  pwr_seq_fsm i_fsm (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .rst_req    (rst_req),
    .thsd       (thsd_flag),
    .wake       (wake_bit),
    .boost_req  (boost_bit),
    .dly_done   (dly_done),
    .state_q    (state_q),
    .boost_on_q (boost_on_q),
    .tmr_clr    (tmr_clr),
    .tmr_run    (tmr_run)
  );

  assign mode      = state_q;
  assign bias_en   = (state_q == MODE_STARTUP) || (state_q == MODE_SOFTST) ||
                     (state_q == MODE_NORMAL);
  assign boost_pfm = (state_q == MODE_SOFTST);
  assign boost_en  = boost_pfm || ((state_q == MODE_NORMAL) && boost_on_q && boost_bit);
  assign func_en   = (state_q == MODE_NORMAL);

endmodule

// File: rtl/pwr_seq_ctrl_chk.sv
module pwr_seq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rst_req,
  input logic       thsd_flag,
  input logic [2:0] state,
  input logic       wake,
  input logic       boost_bit,
  input logic [7:0] vout,
  input logic       boost_en
);

  AST_RESET_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> (state == 3'd0)); // R1

  AST_VOUT_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> (vout == 8'h3F)); // R2

  AST_RESET_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd0 && !rst_req) |=> (state == 3'd1)); // R3

  AST_WAKE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd1 && wake && !rst_req) |=> (state == 3'd2)); // R4

  AST_THSD_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    (state >= 3'd2 && state <= 3'd4 && thsd_flag && wake && !rst_req)
      |=> (state == 3'd2 && !boost_en)); // R6

  AST_BOOST_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd4 && $fell(boost_bit)) |-> !boost_en); // R9

  AST_WAKE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (state != 3'd0 && !wake && !rst_req) |=> (state == 3'd1)); // R10

endmodule

bind pwr_seq_ctrl pwr_seq_ctrl_chk i_chk (
  .clk       (clk),
  .rst_n     (rst_s_n),
  .rst_req   (rst_req),
  .thsd_flag (thsd_flag),
  .state     (state_q),
  .wake      (wake_bit),
  .boost_bit (boost_bit),
  .vout      (vout_q),
  .boost_en  (boost_en)
);

// File: tb/test_pwr_seq_ctrl.sv
module test_pwr_seq_ctrl;

  localparam int unsigned DLY = 16;

  logic       clk;
  logic       rst_n;
  logic       ext_rst_n;
  logic       por_flag;
  logic       thsd_flag;
  logic       wr_en;
  logic [2:0] wr_addr;
  logic [7:0] wr_data;
  logic [2:0] rd_addr;
  logic [7:0] rd_data;
  logic [2:0] mode;
  logic       bias_en;
  logic       boost_en;
  logic       boost_pfm;
  logic       func_en;

  int errors = 0;
  int total  = 0;
  int cyc    = 0;
  bit done   = 0;

  pwr_seq_ctrl #(.DELAY_CYCLES(DLY)) i_pwr_seq_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .ext_rst_n (ext_rst_n),
    .por_flag  (por_flag),
    .thsd_flag (thsd_flag),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .mode      (mode),
    .bias_en   (bias_en),
    .boost_en  (boost_en),
    .boost_pfm (boost_pfm),
    .func_en   (func_en)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct packed {
    logic       wr;
    logic [2:0] addr;
    logic [7:0] data;
    logic       thsd;
    logic [5:0] n;
    logic [2:0] st;
    logic [3:0] outs;   // {bias, boost, pfm, func}
    logic [2:0] raddr;
    logic [7:0] rdat;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 3'd2, 8'hA5, 1'b0, 6'd1,  3'd1, 4'b0000, 3'd2, 8'hA5, 4'd3},  // R3 standby write
    '{1'b1, 3'd0, 8'h03, 1'b0, 6'd2,  3'd2, 4'b1000, 3'd0, 8'h03, 4'd4},  // R4 wake
    '{1'b0, 3'd0, 8'h00, 1'b0, 6'd15, 3'd2, 4'b1000, 3'd1, 8'h3F, 4'd5},  // R5 one short
    '{1'b0, 3'd0, 8'h00, 1'b0, 6'd1,  3'd3, 4'b1110, 3'd0, 8'h03, 4'd5},  // R5 to soft-start
    '{1'b0, 3'd0, 8'h00, 1'b0, 6'd15, 3'd3, 4'b1110, 3'd0, 8'h03, 4'd7},  // R7 one short
    '{1'b0, 3'd0, 8'h00, 1'b0, 6'd1,  3'd4, 4'b1101, 3'd0, 8'h03, 4'd7},  // R7 normal, boost on
    '{1'b1, 3'd0, 8'h01, 1'b0, 6'd1,  3'd4, 4'b1001, 3'd0, 8'h01, 4'd9},  // R9 boost off
    '{1'b1, 3'd0, 8'h03, 1'b0, 6'd1,  3'd4, 4'b1001, 3'd0, 8'h03, 4'd8},  // R8 write edge
    '{1'b0, 3'd0, 8'h00, 1'b0, 6'd1,  3'd3, 4'b1110, 3'd0, 8'h03, 4'd8},  // R8 soft-start
    '{1'b0, 3'd0, 8'h00, 1'b1, 6'd1,  3'd2, 4'b1000, 3'd0, 8'h03, 4'd6},  // R6 from soft-start
    '{1'b0, 3'd0, 8'h00, 1'b1, 6'd20, 3'd2, 4'b1000, 3'd0, 8'h03, 4'd6},  // R6 held
    '{1'b0, 3'd0, 8'h00, 1'b0, 6'd15, 3'd2, 4'b1000, 3'd0, 8'h03, 4'd6},  // R6 full delay
    '{1'b0, 3'd0, 8'h00, 1'b0, 6'd1,  3'd3, 4'b1110, 3'd0, 8'h03, 4'd6},  // R6 delay ends
    '{1'b0, 3'd0, 8'h00, 1'b0, 6'd16, 3'd4, 4'b1101, 3'd0, 8'h03, 4'd7},  // R7
    '{1'b0, 3'd0, 8'h00, 1'b1, 6'd1,  3'd2, 4'b1000, 3'd0, 8'h03, 4'd6},  // R6 from normal
    '{1'b1, 3'd0, 8'h01, 1'b0, 6'd16, 3'd4, 4'b1001, 3'd0, 8'h01, 4'd5},  // R5 no boost
    '{1'b1, 3'd0, 8'h00, 1'b0, 6'd1,  3'd4, 4'b1001, 3'd0, 8'h00, 4'd10}, // R10 write edge
    '{1'b0, 3'd0, 8'h00, 1'b0, 6'd1,  3'd1, 4'b0000, 3'd2, 8'hA5, 4'd10}, // R10 standby
    '{1'b1, 3'd3, 8'h5A, 1'b0, 6'd1,  3'd1, 4'b0000, 3'd3, 8'h5A, 4'd12}  // R12 standby outs
  };

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_wait(input logic [2:0] a, input logic [7:0] d, input int n);
    wr_en   = 1'b1;
    wr_addr = a;
    wr_data = d;
    edges(1);
    wr_en = 1'b0;
    if (n > 1) edges(n - 1);
  endtask

  task automatic read_chk(input string req, input logic [2:0] a, input logic [7:0] exp);
    rd_addr = a;
    #1;
    check(req, int'(rd_data), int'(exp));
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1;
      errors++;
      total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, total);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ext_rst_n = 1'b0; por_flag = 1'b0; thsd_flag = 1'b0;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    edges(3);
    rst_n = 1'b1;
    edges(4);

    // R1 reset state
    check("R1 mode in reset", int'(mode), 0);
    check("R1 enables in reset", int'({bias_en, boost_en, boost_pfm, func_en}), 0);
    // R2 defaults
    for (int a = 0; a < 8; a++)
      read_chk("R2 default", 3'(a), (a == 1) ? 8'h3F : 8'h00);
    // R11 write ignored under reset request
    write_wait(3'd2, 8'h77, 1);
    read_chk("R11 write in reset ignored", 3'd2, 8'h00);
    ext_rst_n = 1'b1;
    edges(1);
    check("R3 mode after release", int'(mode), 1);

    // table walk
    for (int i = 0; i < NV; i++) begin
      thsd_flag = VEC[i].thsd;
      if (VEC[i].wr) write_wait(VEC[i].addr, VEC[i].data, int'(VEC[i].n));
      else edges(int'(VEC[i].n));
      check($sformatf("R%0d row %0d mode", VEC[i].req, i), int'(mode), int'(VEC[i].st));
      check($sformatf("R%0d row %0d enables", VEC[i].req, i),
            int'({bias_en, boost_en, boost_pfm, func_en}), int'(VEC[i].outs));
      read_chk($sformatf("R%0d row %0d readback", VEC[i].req, i), VEC[i].raddr, VEC[i].rdat);
    end

    // R11 full-byte replace, any order
    write_wait(3'd1, 8'hC3, 1);
    read_chk("R11 byte write", 3'd1, 8'hC3);
    write_wait(3'd1, 8'h3C, 1);
    read_chk("R11 all bits flip", 3'd1, 8'h3C);
    write_wait(3'd5, 8'hFF, 1);
    write_wait(3'd4, 8'h11, 1);
    read_chk("R11 order 5", 3'd5, 8'hFF);
    read_chk("R11 order 4", 3'd4, 8'h11);

    // R10 wake drop during startup
    write_wait(3'd0, 8'h01, 2);
    check("R4 startup entry", int'(mode), 2);
    write_wait(3'd0, 8'h00, 1);
    check("R10 write edge still startup", int'(mode), 2);
    edges(1);
    check("R10 back to standby", int'(mode), 1);
    check("R10 enables off", int'({bias_en, boost_en, boost_pfm, func_en}), 0);

    // R1 power-on reset from normal, R2 defaults reapplied
    write_wait(3'd0, 8'h01, 2 + DLY);
    check("R5 normal without boost", int'(mode), 4);
    check("R12 func in normal", int'(func_en), 1);
    por_flag = 1'b1;
    edges(1);
    check("R1 por forces reset", int'(mode), 0);
    check("R1 enables off", int'({bias_en, boost_en, boost_pfm, func_en}), 0);
    read_chk("R2 reg3 cleared", 3'd3, 8'h00);
    read_chk("R2 vout restored", 3'd1, 8'h3F);
    read_chk("R2 ctrl cleared", 3'd0, 8'h00);
    por_flag = 1'b0;
    edges(1);
    check("R3 standby after por", int'(mode), 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, total);
    $finish;
  end

endmodule